// File: doc/BRIEF.md
# Byte-Lane Strobe and Data Steering

This block sits between an access requester and a 16-bit data bus that uses byte addressing. Each cycle it accepts at most one request. A request carries a byte-or-word size select, a direction flag, a wide address and write data. The block registers the request for one cycle and produces the following:

- an upper and a lower lane strobe;
- a 24-bit bus address;
- write data placed on the correct lanes;
- two error flags, one for a misaligned word and one for an illegal size encoding.

On the read side, the block takes the bus read word and combines it with the registered lane strobes. From them it builds a merged read word, in which any unused lane is filled with all ones. It also builds a zero-extended 16-bit value of the byte that a byte read fetched.

A permit input for each direction lets the requester suppress the strobes without withholding the request. Strobes are active high. `busValid` qualifies every registered bus output.

Top module: `lane_steer_top`

## Requirements
- R1: The lower strobe `busLower` (data bits 7:0) is asserted for an accepted word access, or for an accepted byte access whose address bit 0 is 1.
- R2: The upper strobe `busUpper` (data bits 15:8) is asserted for an accepted word access, or for an accepted byte access whose address bit 0 is 0.
- R3: On an accepted byte write, `reqWdata[7:0]` appears on both halves of `busWdata`.
- R4: A word request with address bit 0 set raises `errAddr` and asserts neither strobe.
- R5: On a read, `rdMerged` carries `busRdata` in each lane whose strobe is set and 8'hFF in each lane whose strobe is clear.
- R6: `busAddr` equals bits 23:0 of the request address; higher address bits have no effect on it.
- R7: A request with both `reqByte` and `reqWord` set raises `errSelect` and asserts neither strobe.
- R8: With `permitRd` low a read asserts no strobe, and with `permitWr` low a write asserts no strobe. `busValid` stays low in both cases.
- R9: All bus outputs and error flags are registered, so they appear one clock after the request. After reset, every strobe, `busValid` and both error flags are low.
- R10: After an accepted byte read, `rdByte` holds the strobed lane of `busRdata` zero-extended to 16 bits. At all other times `rdByte` is zero.
- R11: On an accepted word write, `busWdata` equals `reqWdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqByte | input | 1 | Byte size select |
| reqWord | input | 1 | Word size select |
| reqRead | input | 1 | 1 for a read, 0 for a write |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| permitRd | input | 1 | Reads may assert strobes |
| permitWr | input | 1 | Writes may assert strobes |
| busRdata | input | 16 | Read word returned by the bus |
| busValid | output | 1 | Registered access is accepted and strobed |
| busUpper | output | 1 | Upper lane strobe |
| busLower | output | 1 | Lower lane strobe |
| busRead | output | 1 | Direction of the registered access |
| busAddr | output | 24 | Registered bus address |
| busWdata | output | 16 | Lane-steered write data |
| errAddr | output | 1 | Word access at an odd address |
| errSelect | output | 1 | Both size selects were set |
| rdMerged | output | 16 | Read word with unused lanes filled with ones |
| rdByte | output | 16 | Zero-extended byte read value |

## Verification
The registered control state is mainly the pair of lane strobes and the size flag. A fault in either shows up on the very next clock in one of three ways: a strobe on the wrong lane, a write byte present in only one half, or read lanes filled with ones when they should carry data. A wrong acceptance decision shows up on the same clock as a strobe that contradicts a raised error flag or a cleared permit. Stale address or data capture shows up as a `busAddr` or `busWdata` that does not match the request from one cycle earlier.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  // Control bits handed from the control module to the datapath.
  typedef struct packed {
    logic valid;     // accepted and strobed
    logic read;      // direction
    logic byteMode;  // single-lane access
    logic errAddr;   // misaligned word
    logic errSel;    // both size selects set
  } laneCtl_t;

endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqByte,
  input  logic                 reqWord,
  input  logic                 reqRead,
  input  logic [SEL_W-1:0]     laneSel,
  input  logic                 permitRd,
  input  logic                 permitWr,
  output laneCtl_t             ctlNext,
  output laneCtl_t             ctlQ,
  output logic [NUM_LANES-1:0] stbQ
);

  logic selBoth;
  logic oddWord;
  logic oneSize;
  logic permitted;
  logic accept;
  logic [NUM_LANES-1:0] stbNext;

  always_comb begin
    selBoth   = reqByte & reqWord;
    oddWord   = reqWord & ~reqByte & (|laneSel);
    oneSize   = reqByte ^ reqWord;
    permitted = reqRead ? permitRd : permitWr;
    accept    = reqValid & oneSize & ~oddWord & permitted;

    ctlNext.valid    = accept;
    ctlNext.read     = reqRead;
    ctlNext.byteMode = reqByte & ~reqWord;
    ctlNext.errAddr  = reqValid & oddWord;
    ctlNext.errSel   = reqValid & selBoth;
  end

  // Lane 0 is the least significant lane. A byte access selects its lane
  // big-endian, so the lowest byte address maps to the top lane.
  for (genvar i = 0; i < NUM_LANES; i++) begin : gLaneStb
    assign stbNext[i] = accept &
                        (reqWord | (laneSel == SEL_W'(NUM_LANES - 1 - i)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
      stbQ <= '0;
    end else begin
      ctlQ <= ctlNext;
      stbQ <= stbNext;
    end
  end

endmodule

// File: rtl/lane_steer_dp.sv
module lane_steer_dp
  import lane_steer_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LANE_W     = 8,
  parameter int ADDR_IN_W  = 32,
  parameter int BUS_ADDR_W = 24,
  parameter int NUM_LANES  = DATA_W / LANE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  laneCtl_t              ctlNext,
  input  laneCtl_t              ctlQ,
  input  logic [NUM_LANES-1:0]  stbQ,
  input  logic [ADDR_IN_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     busRdata,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     rdMerged,
  output logic [DATA_W-1:0]     rdByte
);

  logic [DATA_W-1:0] wdSteer;
  logic [LANE_W-1:0] pickedLane;

  // Write steering: a byte is replicated on every lane.
  for (genvar i = 0; i < NUM_LANES; i++) begin : gWrLane
    assign wdSteer[i*LANE_W +: LANE_W] =
      ctlNext.byteMode ? reqWdata[LANE_W-1:0] : reqWdata[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busWdata <= '0;
    end else if (ctlNext.valid) begin
      busAddr  <= reqAddr[BUS_ADDR_W-1:0];
      busWdata <= wdSteer;
    end
  end

  // Read merge: lanes that are not strobed read as all ones.
  for (genvar i = 0; i < NUM_LANES; i++) begin : gRdLane
    assign rdMerged[i*LANE_W +: LANE_W] =
      stbQ[i] ? busRdata[i*LANE_W +: LANE_W] : {LANE_W{1'b1}};
  end

  // Byte extraction: OR across the (single) strobed lane.
  always_comb begin
    pickedLane = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (stbQ[i]) pickedLane = pickedLane | busRdata[i*LANE_W +: LANE_W];
    end
    rdByte = '0;
    if (ctlQ.valid && ctlQ.read && ctlQ.byteMode)
      rdByte = {{(DATA_W-LANE_W){1'b0}}, pickedLane};
  end

endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_steer_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LANE_W     = 8,
  parameter int ADDR_IN_W  = 32,
  parameter int BUS_ADDR_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqByte,
  input  logic                  reqWord,
  input  logic                  reqRead,
  input  logic [ADDR_IN_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic                  permitRd,
  input  logic                  permitWr,
  input  logic [DATA_W-1:0]     busRdata,
  output logic                  busValid,
  output logic                  busUpper,
  output logic                  busLower,
  output logic                  busRead,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busWdata,
  output logic                  errAddr,
  output logic                  errSelect,
  output logic [DATA_W-1:0]     rdMerged,
  output logic [DATA_W-1:0]     rdByte
);

  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  laneCtl_t             ctlNext;
  laneCtl_t             ctlQ;
  logic [NUM_LANES-1:0] stbQ;

  lane_steer_ctrl #(.NUM_LANES(NUM_LANES), .SEL_W(SEL_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqByte  (reqByte),
    .reqWord  (reqWord),
    .reqRead  (reqRead),
    .laneSel  (reqAddr[SEL_W-1:0]),
    .permitRd (permitRd),
    .permitWr (permitWr),
    .ctlNext  (ctlNext),
    .ctlQ     (ctlQ),
    .stbQ     (stbQ)
  );

  lane_steer_dp #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_IN_W(ADDR_IN_W),
    .BUS_ADDR_W(BUS_ADDR_W), .NUM_LANES(NUM_LANES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctlNext  (ctlNext),
    .ctlQ     (ctlQ),
    .stbQ     (stbQ),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rdMerged (rdMerged),
    .rdByte   (rdByte)
  );

  assign busValid  = ctlQ.valid;
  assign busRead   = ctlQ.read;
  assign busUpper  = stbQ[NUM_LANES-1];
  assign busLower  = stbQ[0];
  assign errAddr   = ctlQ.errAddr;
  assign errSelect = ctlQ.errSel;

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int DATA_W     = 16,
  parameter int LANE_W     = 8,
  parameter int ADDR_IN_W  = 32,
  parameter int BUS_ADDR_W = 24
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqByte,
  input logic                  reqWord,
  input logic                  reqRead,
  input logic [ADDR_IN_W-1:0]  reqAddr,
  input logic [DATA_W-1:0]     reqWdata,
  input logic                  permitRd,
  input logic                  permitWr,
  input logic [DATA_W-1:0]     busRdata,
  input logic                  busValid,
  input logic                  busUpper,
  input logic                  busLower,
  input logic                  busRead,
  input logic [BUS_ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0]     busWdata,
  input logic                  errAddr,
  input logic                  errSelect,
  input logic [DATA_W-1:0]     rdMerged,
  input logic [DATA_W-1:0]     rdByte
);

  // R1: odd byte address with permit drives only the lower lane.
  a_r1_lower_byte: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqByte && !reqWord && reqAddr[0] &&
     (reqRead ? permitRd : permitWr)) |=> (busLower && !busUpper));

  // R2: even byte address with permit drives only the upper lane.
  a_r2_upper_byte: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqByte && !reqWord && !reqAddr[0] &&
     (reqRead ? permitRd : permitWr)) |=> (busUpper && !busLower));

  // R3: a single-lane write carries the same byte on both halves.
  a_r3_byte_replicate: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busRead && (busUpper != busLower)) |->
      (busWdata[2*LANE_W-1:LANE_W] == busWdata[LANE_W-1:0]));

  // R4: misaligned word -> error and no strobe.
  a_r4_odd_word: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWord && !reqByte && reqAddr[0]) |=>
      (errAddr && !busUpper && !busLower));

  // R5: unstrobed lanes read back as all ones.
  a_r5_fill_low: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busRead && !busLower) |-> (rdMerged[LANE_W-1:0] == {LANE_W{1'b1}}));

  // R7: both size selects -> error and no strobe.
  a_r7_both_sel: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqByte && reqWord) |=> (errSelect && !busUpper && !busLower));

  // R8: a cleared permit blocks the strobes.
  a_r8_permit: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqRead ? !permitRd : !permitWr)) |=>
      (!busUpper && !busLower && !busValid));

  // R9: any strobe implies an accepted access.
  a_r9_strobe_valid: assert property (@(posedge clk) disable iff (!rstN)
    (busUpper || busLower) |-> busValid);

endmodule

bind lane_steer_top lane_steer_chk #(
  .DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_IN_W(ADDR_IN_W), .BUS_ADDR_W(BUS_ADDR_W)
) uChk (.*);

// File: tb/sim_lane_steer_top.sv
`timescale 1ns/1ps
module sim_lane_steer_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqByte = 1'b0, reqWord = 1'b0, reqRead = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        permitRd = 1'b1, permitWr = 1'b1;
  logic [15:0] busRdata;
  logic        busValid, busUpper, busLower, busRead, errAddr, errSelect;
  logic [23:0] busAddr;
  logic [15:0] busWdata, rdMerged, rdByte;

  logic [15:0] mem [64];
  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  assign busRdata = mem[busAddr[6:1]];

  lane_steer_top u0 (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Applies one request, then checks the registered outputs.
  task automatic access(input logic v, input logic b, input logic w, input logic r,
                        input logic [31:0] a, input logic [15:0] d,
                        input logic pr, input logic pw);
    logic legal, acc, eU, eL;
    logic [15:0] eW, eM, eB, word;
    @(negedge clk);
    reqValid = v; reqByte = b; reqWord = w; reqRead = r;
    reqAddr = a; reqWdata = d; permitRd = pr; permitWr = pw;
    legal = (b ^ w) && !(w && !b && a[0]);
    acc   = v && legal && (r ? pr : pw);
    eU    = acc && (w || !a[0]);
    eL    = acc && (w || a[0]);
    eW    = b ? {d[7:0], d[7:0]} : d;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    check("R9", "busValid", busValid, acc);
    check("R2", "busUpper", busUpper, eU);
    check("R1", "busLower", busLower, eL);
    check("R4", "errAddr", errAddr, v && w && !b && a[0]);
    check("R7", "errSelect", errSelect, v && b && w);
    if (!acc) check("R8", "no strobe", {busUpper, busLower}, 2'b00);
    if (acc) begin
      check("R6", "busAddr", busAddr, a[23:0]);
      word = mem[a[6:1]];
      if (r) begin
        eM = {eU ? word[15:8] : 8'hFF, eL ? word[7:0] : 8'hFF};
        check("R5", "rdMerged", rdMerged, eM);
        eB = b ? {8'h00, a[0] ? word[7:0] : word[15:8]} : 16'h0;
        check("R10", "rdByte", rdByte, eB);
      end else begin
        if (b) check("R3", "busWdata", busWdata, eW);
        else   check("R11", "busWdata", busWdata, eW);
        check("R10", "rdByte idle", rdByte, 16'h0);
      end
    end else begin
      check("R10", "rdByte idle", rdByte, 16'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset busValid", busValid, 0);
    check("R9", "reset strobes", {busUpper, busLower}, 2'b00);
    check("R9", "reset errors", {errAddr, errSelect}, 2'b00);
    rstN = 1'b1;

    // Directed corners
    access(1, 1, 0, 0, 32'h0000_0010, 16'h12AB, 1, 1); // R3 even byte write
    access(1, 1, 0, 0, 32'h0000_0011, 16'h34CD, 1, 1); // R3 odd byte write
    access(1, 0, 1, 0, 32'h0000_0020, 16'hBEEF, 1, 1); // R11 word write
    access(1, 0, 1, 1, 32'h0000_0021, 16'h0000, 1, 1); // R4 odd word
    access(1, 1, 1, 1, 32'h0000_0004, 16'h0000, 1, 1); // R7 both selects
    access(1, 1, 0, 1, 32'h0000_0006, 16'h0000, 0, 1); // R8 read blocked
    access(1, 0, 1, 0, 32'h0000_0008, 16'h5555, 1, 0); // R8 write blocked
    access(1, 1, 0, 1, 32'hFF12_3456, 16'h0000, 1, 1); // R6 high bits dropped
    access(1, 1, 0, 1, 32'h0000_0007, 16'h0000, 1, 1); // R5/R10 low lane
    access(1, 0, 1, 1, 32'hABFF_FFFE, 16'h0000, 1, 1); // R5 word read
    access(0, 1, 0, 1, 32'h0000_0002, 16'h0000, 1, 1); // no request

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sz;
      sz = int'($urandom_range(0, 9));
      access($urandom_range(0, 7) != 0,
             (sz < 5) || (sz == 9), (sz >= 5),
             1'($urandom), $urandom, 16'($urandom),
             $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule